// File: doc/BRIEF.md
# Cascade Power Sequencer

This block brings up to four supply converters online one after another. Each channel is given a sequence position, a turn-on delay, a flag that says whether it takes part, and the polarity of its enable pin. A rising edge on the power-on request starts the run. The start can be held back until chosen precondition flags report OK. The block then walks through the positions in ascending order. In each position, every member channel waits out its own delay and then drives its converter enable. The walk moves on once each member reports that its output is above the undervoltage threshold.

A watchdog limits how long any one position may take. If a position stalls, the block enters force shutdown, drops every enable and records the stalled position number. While a run is in progress, the reset output stays asserted and the healthy output stays low. Power-off commands, force-shutdown triggers and new request edges are ignored during this time. Once the highest used position has come up, the block reports that the run is complete.

Top module: `cascade_seq`

## Requirements
- R1: Out of reset, every enable is at its inactive level, fsN is 1, rstOutN is 0, healthy is 0, seqDone is 0 and stallValid is 0.
- R2: A run starts only on a 0-to-1 transition of pwrOnReq while idle. A request held steadily high starts nothing.
- R3: preSel bit 0 selects the supply rail, bit 1 the input rail and bit 2 temperature. With preAll=1 the run waits until all selected preOk bits are 1. With preAll=0 it waits until any one of them is 1. With preSel=0 it does not wait.
- R4: When a position is entered, each member channel asserts its enable after its own delay, counted in milliseconds of CYC_PER_MS clocks. Channels that share a position rise (delay difference × CYC_PER_MS) clocks apart.
- R5: The sequencer moves to the next position only when every member of the current position has its enable asserted and its uvOk high. Enables therefore rise in position order.
- R6: A channel with chanJoin=0, or with position 0, never asserts its enable. Positions that have no member are passed without waiting. The run completes after the highest position in use.
- R7: sttSel selects the per-position limit: 0 = off, 1 = 100 ms, 2 = 200 ms, 3 = 400 ms. If the limit expires before the position completes, fsN goes low, all enables drop, stallValid goes to 1 and stallPos holds the position.
- R8: The watchdog restarts at every position. With sttSel=0 a stall never forces shutdown.
- R9: While a run is in progress, rstOutN is 0 and healthy is 0.
- R10: While a run is in progress, pwrOffCmd, fsTrig and pwrOnReq changes have no effect.
- R11: chanPolHigh=1 drives an enabled channel's pupOut bit to 1. chanPolHigh=0 drives it to 0. The inactive level is the opposite.
- R12: After the last position completes, seqDone and rstOutN are 1, and healthy is 1 exactly while every participating channel has uvOk high.
- R13: After completion, pwrOffCmd drops all enables and clears seqDone. fsTrig drops all enables and drives fsN low, and a later pwrOffCmd releases fsN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrOnReq | input | 1 | Power-on request; a rising edge starts a run |
| pwrOffCmd | input | 1 | Power-off command pulse |
| fsTrig | input | 1 | Force-shutdown trigger pulse |
| preOk | input | 3 | Precondition OK flags: supply rail, input rail, temperature |
| preSel | input | 3 | Which preconditions gate the start |
| preAll | input | 1 | 1 = all selected must be OK, 0 = any one suffices |
| uvOk | input | NUM_CH | Per channel: output above undervoltage threshold |
| chanJoin | input | NUM_CH | Per channel: takes part in the run |
| chanPos | input | NUM_CH*POS_W | Per-channel position, packed, channel 0 in the low bits |
| chanDelay | input | NUM_CH*DLY_W | Per-channel delay in ms, packed |
| chanPolHigh | input | NUM_CH | Per channel: 1 = enable active-high |
| sttSel | input | 2 | Position watchdog setting |
| pupOut | output | NUM_CH | Converter enables, polarity applied |
| fsN | output | 1 | Force shutdown, active low |
| rstOutN | output | 1 | System reset, active low |
| healthy | output | 1 | All participating supplies good after completion |
| seqDone | output | 1 | Run completed |
| stallValid | output | 1 | A position watchdog expired |
| stallPos | output | POS_W | Position that stalled |

## Verification
The assertions assume that the configuration inputs (positions, delays, participation, polarity, watchdog setting) do not change while any enable is asserted. They also assume that uvOk reflects a converter that was switched on, with no spurious highs that would skip a position. The bench changes configuration only after a power-off or a shutdown has cleared the enables. It derives uvOk from the decoded enables, one cycle late, and can hold chosen channels low to create stalls. Command pulses last one cycle and are driven on the falling clock edge.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_POS,
    ST_DONE,
    ST_SHUT
  } seqState_t;

  typedef struct packed {
    logic startSeq;
    logic nextPos;
    logic clearOut;
    logic recordStall;
  } seqStrobe_t;

endpackage

// File: rtl/cseq_datapath.sv
module cseq_datapath
  import cseq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int POS_W       = 3,
  parameter int DLY_W       = 8,
  parameter int CYC_PER_MS  = 100000,
  parameter int STT_BASE_MS = 100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strobe,
  input  logic [NUM_CH*POS_W-1:0] chanPos,
  input  logic [NUM_CH*DLY_W-1:0] chanDelay,
  input  logic [NUM_CH-1:0]       chanJoin,
  input  logic [NUM_CH-1:0]       uvOk,
  input  logic [1:0]              sttSel,
  output logic [NUM_CH-1:0]       enOut,
  output logic [NUM_CH-1:0]       partMask,
  output logic                    posClear,
  output logic                    posIsLast,
  output logic                    noPart,
  output logic                    timeout,
  output logic                    stallValid,
  output logic [POS_W-1:0]        stallPos
);

  localparam int PRE_W  = (CYC_PER_MS > 2) ? $clog2(CYC_PER_MS) : 1;
  localparam int TMR_W  = $clog2(4 * STT_BASE_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [POS_W-1:0]  curPos, loadPos, maxPos;
  logic [NUM_CH-1:0] member, loadHit, armed, enReg;
  logic [PRE_W-1:0]  preCnt;
  logic [TMR_W-1:0]  tmrCnt, tmrLimit;
  logic              tick, entering;

  assign entering = strobe.startSeq | strobe.nextPos;
  assign loadPos  = strobe.startSeq ? POS_W'(1) : curPos + POS_W'(1);
  assign tick     = (preCnt == PRE_LAST);

  // millisecond prescaler, realigned at each position entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          preCnt <= '0;
    else if (entering)  preCnt <= '0;
    else if (tick)      preCnt <= '0;
    else                preCnt <= preCnt + PRE_W'(1);
  end

  // per-channel decode and delay countdown
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
    logic [POS_W-1:0] posOf;
    logic [DLY_W-1:0] dlyCnt;
    assign posOf        = chanPos[gi*POS_W +: POS_W];
    assign partMask[gi] = chanJoin[gi] && (posOf != '0);
    assign member[gi]   = partMask[gi] && (posOf == curPos);
    assign loadHit[gi]  = partMask[gi] && (posOf == loadPos);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dlyCnt     <= '0;
        armed[gi]  <= 1'b0;
        enReg[gi]  <= 1'b0;
      end else if (strobe.clearOut) begin
        armed[gi]  <= 1'b0;
        enReg[gi]  <= 1'b0;
      end else if (entering && loadHit[gi]) begin
        dlyCnt     <= chanDelay[gi*DLY_W +: DLY_W];
        armed[gi]  <= 1'b1;
      end else if (armed[gi]) begin
        if (dlyCnt == '0) begin
          enReg[gi] <= 1'b1;
          armed[gi] <= 1'b0;
        end else if (tick) begin
          dlyCnt <= dlyCnt - DLY_W'(1);
        end
      end
    end

    // R5
    en_in_position_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(enReg[gi]) |-> $past(member[gi]));

    // R6
    no_stray_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !partMask[gi] |-> !enReg[gi]);
  end

  // highest position in use
  always_comb begin
    maxPos = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (partMask[i] && chanPos[i*POS_W +: POS_W] > maxPos)
        maxPos = chanPos[i*POS_W +: POS_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         curPos <= '0;
    else if (entering) curPos <= loadPos;
  end

  // position watchdog
  always_comb begin
    case (sttSel)
      2'd1:    tmrLimit = TMR_W'(STT_BASE_MS);
      2'd2:    tmrLimit = TMR_W'(2 * STT_BASE_MS);
      2'd3:    tmrLimit = TMR_W'(4 * STT_BASE_MS);
      default: tmrLimit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tmrCnt <= '0;
    else if (entering)          tmrCnt <= '0;
    else if (tick && !timeout)  tmrCnt <= tmrCnt + TMR_W'(1);
  end

  assign timeout = (sttSel != 2'd0) && (tmrCnt >= tmrLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallValid <= 1'b0;
      stallPos   <= '0;
    end else if (strobe.startSeq) begin
      stallValid <= 1'b0;
    end else if (strobe.recordStall) begin
      stallValid <= 1'b1;
      stallPos   <= curPos;
    end
  end

  // R7
  stall_recorded_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recordStall |=> (stallValid && stallPos == $past(curPos)));

  assign posClear  = &(~member | (enReg & uvOk));
  assign posIsLast = (curPos >= maxPos);
  assign noPart    = (partMask == '0);
  assign enOut     = enReg;

endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
  import cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrOnReq,
  input  logic       pwrOffCmd,
  input  logic       fsTrig,
  input  logic [2:0] preOk,
  input  logic [2:0] preSel,
  input  logic       preAll,
  input  logic       posClear,
  input  logic       posIsLast,
  input  logic       noPart,
  input  logic       timeout,
  output seqState_t  state,
  output seqStrobe_t strobe
);

  seqState_t stateNxt;
  logic      pwrOnQ, reqRise, preMet;

  assign reqRise = pwrOnReq & ~pwrOnQ;

  always_comb begin
    if (preSel == 3'b000) preMet = 1'b1;
    else if (preAll)      preMet = &(preOk | ~preSel);
    else                  preMet = |(preOk & preSel);
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (fsTrig) begin
          strobe.clearOut = 1'b1;
          stateNxt = ST_SHUT;
        end else if (reqRise) begin
          stateNxt = ST_PRE;
        end
      end
      ST_PRE: begin
        if (preMet) begin
          if (noPart) stateNxt = ST_DONE;
          else begin
            strobe.startSeq = 1'b1;
            stateNxt = ST_POS;
          end
        end
      end
      ST_POS: begin
        if (posClear) begin
          if (posIsLast) stateNxt = ST_DONE;
          else strobe.nextPos = 1'b1;
        end else if (timeout) begin
          strobe.recordStall = 1'b1;
          strobe.clearOut    = 1'b1;
          stateNxt = ST_SHUT;
        end
      end
      ST_DONE: begin
        if (fsTrig) begin
          strobe.clearOut = 1'b1;
          stateNxt = ST_SHUT;
        end else if (pwrOffCmd) begin
          strobe.clearOut = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      ST_SHUT: begin
        if (pwrOffCmd) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pwrOnQ <= 1'b0;
    end else begin
      state  <= stateNxt;
      pwrOnQ <= pwrOnReq;
    end
  end

  // R10
  seq_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POS && !timeout) |=> (state == ST_POS || state == ST_DONE));

  // R2
  idle_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !reqRise && !fsTrig) |=> state == ST_IDLE);

endmodule

// File: rtl/cascade_seq.sv
module cascade_seq
  import cseq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int POS_W       = 3,
  parameter int DLY_W       = 8,
  parameter int CYC_PER_MS  = 100000,
  parameter int STT_BASE_MS = 100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pwrOnReq,
  input  logic                    pwrOffCmd,
  input  logic                    fsTrig,
  input  logic [2:0]              preOk,
  input  logic [2:0]              preSel,
  input  logic                    preAll,
  input  logic [NUM_CH-1:0]       uvOk,
  input  logic [NUM_CH-1:0]       chanJoin,
  input  logic [NUM_CH*POS_W-1:0] chanPos,
  input  logic [NUM_CH*DLY_W-1:0] chanDelay,
  input  logic [NUM_CH-1:0]       chanPolHigh,
  input  logic [1:0]              sttSel,
  output logic [NUM_CH-1:0]       pupOut,
  output logic                    fsN,
  output logic                    rstOutN,
  output logic                    healthy,
  output logic                    seqDone,
  output logic                    stallValid,
  output logic [POS_W-1:0]        stallPos
);

  seqState_t         state;
  seqStrobe_t        strobe;
  logic [NUM_CH-1:0] enOut, partMask;
  logic              posClear, posIsLast, noPart, timeout;

  cseq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pwrOnReq  (pwrOnReq),
    .pwrOffCmd (pwrOffCmd),
    .fsTrig    (fsTrig),
    .preOk     (preOk),
    .preSel    (preSel),
    .preAll    (preAll),
    .posClear  (posClear),
    .posIsLast (posIsLast),
    .noPart    (noPart),
    .timeout   (timeout),
    .state     (state),
    .strobe    (strobe)
  );

  cseq_datapath #(
    .NUM_CH      (NUM_CH),
    .POS_W       (POS_W),
    .DLY_W       (DLY_W),
    .CYC_PER_MS  (CYC_PER_MS),
    .STT_BASE_MS (STT_BASE_MS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .chanPos    (chanPos),
    .chanDelay  (chanDelay),
    .chanJoin   (chanJoin),
    .uvOk       (uvOk),
    .sttSel     (sttSel),
    .enOut      (enOut),
    .partMask   (partMask),
    .posClear   (posClear),
    .posIsLast  (posIsLast),
    .noPart     (noPart),
    .timeout    (timeout),
    .stallValid (stallValid),
    .stallPos   (stallPos)
  );

  assign pupOut  = enOut ~^ chanPolHigh;
  assign seqDone = (state == ST_DONE);
  assign rstOutN = (state == ST_DONE);
  assign healthy = (state == ST_DONE) && (&(~partMask | uvOk));
  assign fsN     = (state != ST_SHUT);

  // R9
  busy_holds_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE || state == ST_POS) |-> (!rstOutN && !healthy));

endmodule

// File: tb/cascade_seq_tb_top.sv
module cascade_seq_tb_top;

  localparam int NUM_CH = 4;
  localparam int POS_W  = 3;
  localparam int DLY_W  = 8;
  localparam int CPM    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrOnReq = 1'b0, pwrOffCmd = 1'b0, fsTrig = 1'b0;
  logic [2:0] preOk = 3'b000, preSel = 3'b000;
  logic preAll = 1'b1;
  logic [NUM_CH-1:0] uvOk = '0, chanJoin, chanPolHigh, stuck = '0;
  logic [NUM_CH*POS_W-1:0] chanPos;
  logic [NUM_CH*DLY_W-1:0] chanDelay;
  logic [1:0] sttSel = 2'd0;
  logic [NUM_CH-1:0] pupOut;
  logic fsN, rstOutN, healthy, seqDone, stallValid;
  logic [POS_W-1:0] stallPos;

  logic [NUM_CH-1:0] enDec, prevEn = '0, idlePat;
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int riseTime[NUM_CH];
  int expQ[$];
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cascade_seq #(.NUM_CH(NUM_CH), .POS_W(POS_W), .DLY_W(DLY_W), .CYC_PER_MS(CPM)) dut_i (
    .clk(clk), .rstN(rstN), .pwrOnReq(pwrOnReq), .pwrOffCmd(pwrOffCmd), .fsTrig(fsTrig),
    .preOk(preOk), .preSel(preSel), .preAll(preAll), .uvOk(uvOk), .chanJoin(chanJoin),
    .chanPos(chanPos), .chanDelay(chanDelay), .chanPolHigh(chanPolHigh), .sttSel(sttSel),
    .pupOut(pupOut), .fsN(fsN), .rstOutN(rstOutN), .healthy(healthy), .seqDone(seqDone),
    .stallValid(stallValid), .stallPos(stallPos));

  assign enDec   = pupOut ~^ chanPolHigh;
  assign idlePat = ~chanPolHigh;

  // supply model: output good one cycle after enable unless held stuck
  always @(negedge clk) uvOk <= enDec & ~stuck;

  // monitor: pops the expected enable order from the scoreboard
  always @(negedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (enDec[i] && !prevEn[i]) begin
        riseTime[i] = cyc;
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R5/R6 unexpected enable ch%0d: actual rise, expected none", i);
        end else begin
          int e;
          e = expQ.pop_front();
          if (e != i) begin
            failures++;
            $display("FAIL R5 enable order: actual ch%0d expected ch%0d", i, e);
          end
        end
      end
    end
    prevEn <= enDec;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkRange(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitDone(int lim);
    for (int k = 0; k < lim && !seqDone; k++) @(negedge clk);
    cycles(3);
  endtask

  task automatic pulseOff();
    @(negedge clk) pwrOffCmd = 1'b1;
    @(negedge clk) pwrOffCmd = 1'b0;
  endtask

  task automatic startRun();
    @(negedge clk) pwrOnReq = 1'b0;
    @(negedge clk) pwrOnReq = 1'b1;
  endtask

  task automatic setDelays(int d0, int d1, int d2, int d3);
    chanDelay = {DLY_W'(d3), DLY_W'(d2), DLY_W'(d1), DLY_W'(d0)};
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual hung expected finished");
    finish();
  end

  initial begin
    int fsFall;
    // ch0 pos1, ch3 pos2 (not joined), ch1/ch2 share pos3
    chanPos     = {3'd2, 3'd3, 3'd3, 3'd1};
    chanJoin    = 4'b0111;
    chanPolHigh = 4'b1011;
    setDelays(2, 1, 4, 0);
    cycles(3);
    check("R1 pupOut idle", pupOut, 4'b0100);
    check("R11 active-low idle high", pupOut[2], 1);
    check("R1 fsN", fsN, 1);
    check("R1 rstOutN", rstOutN, 0);
    check("R1 healthy", healthy, 0);
    check("R1 seqDone", seqDone, 0);
    check("R1 stallValid", stallValid, 0);
    @(negedge clk) rstN = 1'b1;
    cycles(3);

    // main run with ignored commands mid-sequence
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(2);
    @(negedge clk) pwrOnReq = 1'b1;
    cycles(3);
    check("R9 rstOutN during run", rstOutN, 0);
    check("R9 healthy during run", healthy, 0);
    pulseOff();
    @(negedge clk) fsTrig = 1'b1;
    @(negedge clk) fsTrig = 1'b0;
    startRun();
    check("R10 fsN after ignored trigger", fsN, 1);
    waitDone(600);
    check("R10 run completed despite commands", seqDone, 1);
    check("R4 shared-position spacing", riseTime[2] - riseTime[1], 3 * CPM);
    check("R6 non-participant off", enDec[3], 0);
    check("R11 active-low enabled low", pupOut[2], 0);
    check("R5 order queue drained", expQ.size(), 0);
    check("R12 rstOutN", rstOutN, 1);
    check("R12 healthy", healthy, 1);
    stuck = 4'b0001;
    cycles(2);
    check("R12 healthy follows uvOk", healthy, 0);
    stuck = '0;
    cycles(2);
    check("R12 healthy restored", healthy, 1);
    pulseOff();
    check("R13 off drops enables", pupOut, idlePat);
    check("R13 off clears seqDone", seqDone, 0);
    cycles(40);
    check("R2 held request no restart", pupOut, idlePat);

    // precondition gating (all mode)
    @(negedge clk) pwrOnReq = 1'b0;
    preSel = 3'b011; preAll = 1'b1; preOk = 3'b001;
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(2);
    @(negedge clk) pwrOnReq = 1'b1;
    cycles(30);
    check("R3 held off while precondition missing", pupOut, idlePat);
    preOk = 3'b011;
    waitDone(600);
    check("R3 run after preconditions", seqDone, 1);
    pulseOff();
    // any mode
    preAll = 1'b0; preOk = 3'b010;
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(2);
    startRun();
    waitDone(600);
    check("R3 any-mode run", seqDone, 1);
    pulseOff();
    preSel = 3'b000;

    // watchdog expiry at position 3
    sttSel = 2'd1; stuck = 4'b0010;
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(2);
    startRun();
    fsFall = -1;
    for (int k = 0; k < 1500 && fsFall < 0; k++) begin
      @(negedge clk);
      if (!fsN) fsFall = cyc;
    end
    checkRange("R7 timeout latency", fsFall - riseTime[1], 100 * CPM - 10, 100 * CPM + 2);
    check("R7 stallValid", stallValid, 1);
    check("R7 stallPos", stallPos, 3);
    check("R7 enables dropped", pupOut, idlePat);
    pulseOff();
    check("R13 fsN released", fsN, 1);
    stuck = '0;

    // long run, each position under the limit
    setDelays(60, 1, 80, 0);
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(2);
    startRun();
    waitDone(3000);
    check("R8 restart per position", seqDone, 1);
    check("R8 no shutdown", fsN, 1);
    check("R7 stall cleared on new run", stallValid, 0);
    pulseOff();

    // watchdog off
    setDelays(2, 1, 4, 0);
    sttSel = 2'd0; stuck = 4'b0010;
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(2);
    startRun();
    cycles(2000);
    check("R8 off never shuts down", fsN, 1);
    check("R8 still waiting", seqDone, 0);
    stuck = '0;
    waitDone(100);
    check("R8 completes once good", seqDone, 1);

    // force shutdown after completion
    @(negedge clk) fsTrig = 1'b1;
    @(negedge clk) fsTrig = 1'b0;
    check("R13 fsTrig fsN low", fsN, 0);
    check("R13 fsTrig drops enables", pupOut, idlePat);
    pulseOff();
    check("R13 fsN released after off", fsN, 1);
    check("R5 queue empty at end", expQ.size(), 0);
    finish();
  end

endmodule